// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus for a small 8-bit controller core. The address-latch strobe (ALE, active high) tells an external latch when the low address byte is on the shared pins. The program-read strobe (PSEN, active low) is the read enable for external code memory. The core supplies a 4-bit machine-cycle phase index. A machine cycle has twelve oscillator clocks, counted 0 to 11 (S1P1 = 0 through S6P2 = 11). At phase 0 the core also presents the attributes of the coming cycle: the fetch address, whether the cycle moves data to or from external data memory, whether the instruction in progress is a data-move or code-table-read instruction, and the ALE-suppress control bit.

A cycle-kind state machine classifies every machine cycle at phase 0 and holds that classification for the whole cycle. A strobe shaper turns the kind and the phase into registered pin values. A steering unit samples the external-access pin while reset is asserted and keeps that level afterwards. It also decides whether each fetch goes to internal or external code memory. The ALE pin has a separate output enable. When ALE is suppressed, the pin is released to a weak pull-up: the enable is low and the value reads high.

States of the cycle-kind machine: `ST_WAIT` (after reset, before the first phase 0), `ST_FETCH_INT` (internal code fetch), `ST_FETCH_EXT` (external code fetch), `ST_DATA_EXT` (external data-memory cycle) and `ST_ALE_QUIET` (internal fetch with ALE released). A single transition rule applies, named *classify*. When phase 0 is presented, the next state is chosen in this priority order: `ST_DATA_EXT` if the data-cycle flag is set; else `ST_FETCH_EXT` if the fetch is external; else `ST_ALE_QUIET` if the suppress bit is set and the instruction flag is clear; else `ST_FETCH_INT`. At every other phase the state holds. Reset returns the machine to `ST_WAIT`.

Top module: `bus_strobe_gen`

## Requirements
- R1: Output timing and the ordinary ALE pattern. Every output is registered: the values seen in the clock after a phase index is presented belong to that phase. In an ordinary cycle, ALE is driven (ale_oe = 1) high for phases 1 and 2 and for phases 7 and 8. At every other phase it is driven low. This gives two pulses per twelve clocks.
- R2: With the held external-access level high, a fetch address below 0x1000 is internal and psen_n stays 1 for the whole cycle. An address of 0x1000 or above is external.
- R3: With the held external-access level low, every fetch address, including 0x0000 and 0x0FFF, is external.
- R4: In an external fetch cycle, psen_n is 0 for phases 3, 4 and 5 and for phases 9, 10 and 11, and 1 at all other phases.
- R5: In a cycle flagged as an external data access, the ALE pulse at phases 1 and 2 is skipped, the ALE pulse at phases 7 and 8 remains, and both PSEN pulses are skipped, whatever the fetch address.
- R6: With the suppress bit set, an internal fetch and the instruction flag clear, ale_oe is 0 and ale reads 1 for all twelve phases, and psen_n stays 1.
- R7: With the suppress bit set and the instruction flag set, ALE is driven and pulses as in R1.
- R8: The suppress bit has no effect on a cycle whose fetch is external: ALE is driven and pulses as in R1.
- R9: The external-access pin is sampled only while rst_n is low. Later changes of the pin do not change how fetches are steered.
- R10: Fetch address, data-cycle flag, instruction flag and suppress bit are sampled only at phase 0. Changing them during phases 1 to 11 does not change the current cycle.
- R11: While rst_n is low, and after release until the first phase 0 is presented, the outputs rest at ale = 0, ale_oe = 1, psen_n = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Reset, active low |
| ea_pin | input | 1 | External-access pin level, sampled during reset |
| phase | input | 4 | Machine-cycle phase index, 0 to 11 |
| fetch_addr | input | 16 | Code fetch address of the cycle, sampled at phase 0 |
| movx_cycle | input | 1 | Cycle is an external data-memory access, sampled at phase 0 |
| movx_movc | input | 1 | Current instruction is a data-move or code-table read, sampled at phase 0 |
| ale_off | input | 1 | ALE suppress control bit, sampled at phase 0 |
| ale | output | 1 | Address latch strobe value |
| ale_oe | output | 1 | ALE driver enable; 0 means released to weak pull-up |
| psen_n | output | 1 | Program read strobe, active low |

## Verification
The bench targets the address boundary at 0x0FFF and 0x1000 under both held external-access levels. A wrong compare would put a PSEN pulse on the last internal byte, or drop it on the first external byte. External data cycles are run back to back and with internal addresses. A design that skipped the wrong ALE pulse, or kept PSEN, shows a pulse pattern that is out of phase. The suppress bit is crossed with the instruction flag and with external execution, so a missing override shows up as a released ALE pin in those cycles. The pin and the cycle attributes are also toggled after reset and in the middle of a cycle. This catches a design that resamples them and changes strobes part-way through.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    // machine cycle geometry
    localparam int PH_W       = 4;
    localparam int PHASES     = 12;
    localparam int CYC_START  = 0;

    // strobe windows (inclusive phase indices)
    localparam int ALE_A_LO   = 1;
    localparam int ALE_A_HI   = 2;
    localparam int ALE_B_LO   = 7;
    localparam int ALE_B_HI   = 8;
    localparam int RD_A_LO    = 3;
    localparam int RD_A_HI    = 5;
    localparam int RD_B_LO    = 9;
    localparam int RD_B_HI    = 11;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_FETCH_INT,
        ST_FETCH_EXT,
        ST_DATA_EXT,
        ST_ALE_QUIET
    } cyc_state_e;

    typedef struct packed {
        logic ale;
        logic ale_oe;
        logic psen_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ale: 1'b0, ale_oe: 1'b1, psen_n: 1'b1};

    function automatic logic in_window(input logic [PH_W-1:0] ph, input int lo, input int hi);
        return (int'(ph) >= lo) && (int'(ph) <= hi);
    endfunction

endpackage

// File: rtl/fetch_steer.sv
module fetch_steer #(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              ext_fetch
);
    localparam logic [ADDR_W-1:0] INT_LIMIT = ADDR_W'(INT_BYTES);

    logic ea_held;

    // pin level follows the input only while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_held <= ea_pin;
        end
    end

    always_comb begin
        ext_fetch = (!ea_held) || (fetch_addr >= INT_LIMIT);
    end

    assert_ea_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ea_held == $past(ea_held));

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import bus_strobe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  logic            ext_fetch,
    input  logic            data_cyc,
    input  logic            mv_instr,
    input  logic            ale_off,
    output cyc_state_e      state_nxt
);
    cyc_state_e state;
    cyc_state_e kind;

    // classify: priority data cycle, external fetch, quiet, internal
    always_comb begin
        if (data_cyc) begin
            kind = ST_DATA_EXT;
        end else if (ext_fetch) begin
            kind = ST_FETCH_EXT;
        end else if (ale_off && !mv_instr) begin
            kind = ST_ALE_QUIET;
        end else begin
            kind = ST_FETCH_INT;
        end
    end

    always_comb begin
        if (int'(phase) == CYC_START) begin
            state_nxt = kind;
        end else begin
            state_nxt = state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    assert_kind_changes_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (int'($past(phase)) == CYC_START));

endmodule

// File: rtl/strobe_shaper.sv
module strobe_shaper
    import bus_strobe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase,
    input  cyc_state_e      state_nxt,
    output strobe_t         pins
);
    strobe_t pins_d;
    logic    ale_a, ale_b, rd_win;

    always_comb begin
        ale_a  = in_window(phase, ALE_A_LO, ALE_A_HI);
        ale_b  = in_window(phase, ALE_B_LO, ALE_B_HI);
        rd_win = in_window(phase, RD_A_LO, RD_A_HI) || in_window(phase, RD_B_LO, RD_B_HI);
    end

    always_comb begin
        pins_d = STROBE_REST;
        unique case (state_nxt)
            ST_WAIT: begin
                pins_d = STROBE_REST;
            end
            ST_FETCH_INT: begin
                pins_d.ale = ale_a || ale_b;
            end
            ST_FETCH_EXT: begin
                pins_d.ale    = ale_a || ale_b;
                pins_d.psen_n = !rd_win;
            end
            ST_DATA_EXT: begin
                pins_d.ale = ale_b;
            end
            ST_ALE_QUIET: begin
                pins_d.ale    = 1'b1;
                pins_d.ale_oe = 1'b0;
            end
            default: begin
                pins_d = STROBE_REST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins <= STROBE_REST;
        end else begin
            pins <= pins_d;
        end
    end

    assert_read_opens_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pins.psen_n) |-> (int'($past(phase)) == RD_A_LO || int'($past(phase)) == RD_B_LO));

    assert_data_cycle_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_nxt) == ST_DATA_EXT) |-> pins.psen_n);

    assert_released_reads_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.ale_oe |-> pins.ale);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_pin,
    input  logic [PH_W-1:0]   phase,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              movx_cycle,
    input  logic              movx_movc,
    input  logic              ale_off,
    output logic              ale,
    output logic              ale_oe,
    output logic              psen_n
);
    logic       ext_fetch;
    cyc_state_e state_nxt;
    strobe_t    pins;

    fetch_steer #(.ADDR_W(ADDR_W), .INT_BYTES(INT_BYTES)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ea_pin     (ea_pin),
        .fetch_addr (fetch_addr),
        .ext_fetch  (ext_fetch)
    );

    cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .ext_fetch (ext_fetch),
        .data_cyc  (movx_cycle),
        .mv_instr  (movx_movc),
        .ale_off   (ale_off),
        .state_nxt (state_nxt)
    );

    strobe_shaper u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .state_nxt (state_nxt),
        .pins      (pins)
    );

    always_comb begin
        ale    = pins.ale;
        ale_oe = pins.ale_oe;
        psen_n = pins.psen_n;
    end

    assert_latch_and_read_disjoint_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && ale_oe && !psen_n));

    assert_latch_rises_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ale) && ale_oe) |-> (int'($past(phase)) == ALE_A_LO || int'($past(phase)) == ALE_B_LO));

endmodule

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;

    typedef struct {
        logic  ale;
        logic  oe;
        logic  psen;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ea_pin = 1'b1;
    logic [3:0]  phase = 4'd0;
    logic [15:0] fetch_addr = 16'h0;
    logic        movx_cycle = 1'b0;
    logic        movx_movc = 1'b0;
    logic        ale_off = 1'b0;
    logic        ale, ale_oe, psen_n;

    int   n_checks = 0;
    int   n_errors = 0;
    logic ea_expect = 1'b1;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t it;

    always #2.5 clk = ~clk;

    bus_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .phase(phase),
        .fetch_addr(fetch_addr), .movx_cycle(movx_cycle), .movx_movc(movx_movc),
        .ale_off(ale_off), .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (ale !== e.ale || ale_oe !== e.oe || psen_n !== e.psen) begin
            n_errors++;
            $display("FAIL %s: got ale=%b oe=%b psen_n=%b, expected ale=%b oe=%b psen_n=%b",
                     e.tag, ale, ale_oe, psen_n, e.ale, e.oe, e.psen);
        end
    endtask

    // monitor: one result per clock, registered output of the previous phase
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            compare(it);
        end
    end

    function automatic exp_t model(input int ph, input logic ext, input logic mv,
                                   input logic ins, input logic off, input string tag);
        exp_t e;
        logic a1, a2, rd;
        a1 = (ph == 1 || ph == 2);
        a2 = (ph == 7 || ph == 8);
        rd = (ph >= 3 && ph <= 5) || (ph >= 9 && ph <= 11);
        e.tag = tag; e.oe = 1'b1; e.psen = 1'b1; e.ale = 1'b0;
        if (mv) begin
            e.ale = a2;
        end else if (!ext && off && !ins) begin
            e.ale = 1'b1; e.oe = 1'b0;
        end else begin
            e.ale = a1 | a2;
            e.psen = !(ext && rd);
        end
        return e;
    endfunction

    task automatic run_cycle(input logic [15:0] addr, input logic mv, input logic ins,
                             input logic off, input logic scr, input string tag);
        logic ext;
        ext = !ea_expect || (addr >= 16'h1000);
        for (int ph = 0; ph < 12; ph++) begin
            @(negedge clk);
            phase = 4'(ph);
            if (ph == 0 || !scr) begin
                fetch_addr = addr; movx_cycle = mv; movx_movc = ins; ale_off = off;
            end else begin
                fetch_addr = ~addr; movx_cycle = ~mv; movx_movc = ~ins; ale_off = ~off;
            end
            sb_q.push_back(model(ph, ext, mv, ins, off, tag));
        end
    endtask

    task automatic idle_step(input int ph);
        exp_t e;
        @(negedge clk);
        phase = 4'(ph);
        e.ale = 1'b0; e.oe = 1'b1; e.psen = 1'b1; e.tag = "R11";
        sb_q.push_back(e);
    endtask

    task automatic do_reset(input logic ea_level);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; ea_pin = ea_level; phase = 4'd0;
        repeat (3) @(negedge clk);
        e.ale = 1'b0; e.oe = 1'b1; e.psen = 1'b1; e.tag = "R11";
        compare(e);
        phase = 4'd15;
        rst_n = 1'b1;
        ea_expect = ea_level;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // held access level high
        do_reset(1'b1);
        idle_step(15); idle_step(5); idle_step(11);                 // R11 no cycle before phase 0
        run_cycle(16'h0100, 0, 0, 0, 0, "R1");
        run_cycle(16'h0FFF, 0, 0, 0, 0, "R2");
        run_cycle(16'h1000, 0, 0, 0, 0, "R2");
        run_cycle(16'hFFFF, 0, 0, 0, 0, "R4");
        run_cycle(16'h2345, 1, 1, 0, 0, "R5");
        run_cycle(16'h2345, 1, 1, 0, 0, "R5");
        run_cycle(16'h0040, 1, 1, 1, 0, "R5");
        run_cycle(16'h0200, 0, 0, 1, 0, "R6");
        run_cycle(16'h0200, 0, 1, 1, 0, "R7");
        run_cycle(16'h8000, 0, 0, 1, 0, "R8");
        run_cycle(16'h0300, 0, 0, 1, 1, "R10");
        run_cycle(16'h1800, 0, 0, 0, 1, "R10");
        run_cycle(16'h0FFF, 1, 1, 0, 1, "R10");
        @(negedge clk); ea_pin = 1'b0;
        run_cycle(16'h0010, 0, 0, 0, 0, "R9");
        run_cycle(16'h0010, 0, 0, 1, 0, "R9");

        // held access level low
        do_reset(1'b0);
        idle_step(15); idle_step(3);
        run_cycle(16'h0000, 0, 0, 0, 0, "R3");
        run_cycle(16'h0FFF, 0, 0, 0, 0, "R3");
        run_cycle(16'h0010, 0, 0, 1, 0, "R8");
        run_cycle(16'h0010, 1, 0, 1, 0, "R5");
        @(negedge clk); ea_pin = 1'b1;
        run_cycle(16'h0000, 0, 0, 0, 0, "R9");

        @(negedge clk); phase = 4'd15;
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule